// File: doc/BRIEF.md
# Voltage Detector Reaction Controller

This block sits between a bank of supply-voltage detectors and the chip's reset and fault infrastructure. It receives one threshold-crossing flag per detector, brings each flag into the local clock domain and, on every new crossing, records a pending flag. Per-detector settings then pick the reactions: none (monitor only), a functional reset request, a destructive reset that pulls the external reset pin low, a fault-collection event and an interrupt. Any combination may be active at once.

Software programs five per-detector registers through a simple write port with a combinational read port. At boot, a configuration loader presents a per-detector enable vector with a load strobe. Each detector it enables is locked into reset reaction: its reset-enable bit reads 1, and software cannot clear it until a later boot load clears that enable. While any detector that is enabled for destructive reset still sees its condition, the block asserts a hold output. The first reset phase uses this hold, and the external reset pin follows it.

Top module: `vdr_reaction_ctrl`

## Requirements
- R1: After reset, the registers read as follows: reset enable (address 0) 0, reset type (address 1) all ones (1 = destructive, 0 = functional), pending (address 2) 0, interrupt enable (address 3) 0, fault enable (address 4) 0. Addresses 5 to 7 read 0.
- R2: A 0-to-1 change on a detector flag that stays stable across two clock edges sets that detector's pending bit at the third clock edge after the change, whatever the enables are.
- R3: A boot load sets the reset-enable bit of every detector whose boot enable is 1 and locks it. While it is locked, the bit reads 1 and software writes of 0 to it have no effect. A boot load takes priority over a reset-enable write in the same cycle.
- R4: When a detector with reset enable 1 and reset type 0 has a captured rising edge, funcResetReq pulses for one cycle at the same edge that sets its pending bit.
- R5: While the synchronised flag of a detector with reset enable 1 and reset type 1 is high, destHold is 1 and resetPinN is 0. Both respond one clock after the synchronised level.
- R6: destHold stays asserted until no detector has an active destructive condition. It releases one clock after the last such condition clears.
- R7: irq is high exactly when some pending bit has its interrupt-enable bit set. Writing 1 to a pending bit clears it, and a new capture in the same cycle wins over the clear.
- R8: A boot load with a detector's enable at 0 unlocks that bit. It keeps its value, but software writes take effect again.
- R9: The faultEvent bit of a detector pulses for one cycle when its rising edge is captured while its fault enable is 1. A detector with no enables changes only its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| detFlag | input | NUM_DET | Raw threshold-crossing flags from the detectors |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address for write and read |
| busWrData | input | NUM_DET | Register write data |
| busRdData | output | NUM_DET | Combinational read data for busAddr |
| bootLoad | input | 1 | One-cycle strobe from the configuration loader |
| bootEnable | input | NUM_DET | Boot-time reset-enable vector |
| irq | output | 1 | Interrupt request |
| faultEvent | output | NUM_DET | Per-detector fault-collection event pulses |
| funcResetReq | output | 1 | Functional reset request pulse |
| destHold | output | 1 | Destructive-reset hold for the reset sequencer |
| resetPinN | output | 1 | External reset pin drive, low while destructive hold is active |

## Verification
A stale lock or enable bit shows up on the next read of address 0, and on the very next crossing as a missing or extra reset pulse, or as a pin that drops when it should not. A pending bit captured on the wrong edge, or cleared on the wrong write, shows on irq and in the readback within the same cycle. The bench carries a behavioural model that is checked on every clock. A fault therefore surfaces within three cycles of the stimulus that exposes it, and the hold-release ordering is checked with overlapping destructive conditions on several detectors.

// File: rtl/vdr_pkg.sv
package vdr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RST_EN   = 3'd0,
    REG_RST_TYPE = 3'd1,
    REG_PEND     = 3'd2,
    REG_IRQ_EN   = 3'd3,
    REG_FAULT_EN = 3'd4
  } regSel_e;

  typedef struct packed {
    logic wrRstEn;
    logic wrRstType;
    logic clrPend;
    logic wrIrqEn;
    logic wrFaultEn;
    logic bootLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/vdr_sync.sv
module vdr_sync #(
  parameter int NUM_DET = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DET-1:0] rawFlag,
  output logic [NUM_DET-1:0] syncLvl,
  output logic [NUM_DET-1:0] riseEdge
);
  logic [NUM_DET-1:0] chain [STAGES];
  logic [NUM_DET-1:0] prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= rawFlag;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= chain[STAGES-1];
  end

  assign syncLvl  = chain[STAGES-1];
  assign riseEdge = syncLvl & ~prevLvl;
endmodule

// File: rtl/vdr_ctrl.sv
module vdr_ctrl
  import vdr_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              bootLoad,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes          = '0;
    strobes.bootLoad = bootLoad;
    if (busWrEn) begin
      case (regSel_e'(busAddr))
        REG_RST_EN:   strobes.wrRstEn   = 1'b1;
        REG_RST_TYPE: strobes.wrRstType = 1'b1;
        REG_PEND:     strobes.clrPend   = 1'b1;
        REG_IRQ_EN:   strobes.wrIrqEn   = 1'b1;
        REG_FAULT_EN: strobes.wrFaultEn = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/vdr_datapath.sv
module vdr_datapath
  import vdr_pkg::*;
#(
  parameter int NUM_DET = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_DET-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [NUM_DET-1:0] bootEnable,
  input  logic [NUM_DET-1:0] syncLvl,
  input  logic [NUM_DET-1:0] riseEdge,
  output logic [NUM_DET-1:0] rdData,
  output logic               irq,
  output logic [NUM_DET-1:0] faultEvent,
  output logic               funcResetReq,
  output logic               destHold
);
  logic [NUM_DET-1:0] rstEnReg, rstTypeReg, pendReg, irqEnReg, faultEnReg, lockMask;
  logic [NUM_DET-1:0] clrMask;

  assign clrMask = strobes.clrPend ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstEnReg     <= '0;
      rstTypeReg   <= '1;
      pendReg      <= '0;
      irqEnReg     <= '0;
      faultEnReg   <= '0;
      lockMask     <= '0;
      faultEvent   <= '0;
      funcResetReq <= 1'b0;
      destHold     <= 1'b0;
    end else begin
      if (strobes.bootLoad) begin
        lockMask <= bootEnable;
        rstEnReg <= rstEnReg | bootEnable;
      end else if (strobes.wrRstEn) begin
        rstEnReg <= wrData | lockMask;
      end
      if (strobes.wrRstType) rstTypeReg <= wrData;
      if (strobes.wrIrqEn)   irqEnReg   <= wrData;
      if (strobes.wrFaultEn) faultEnReg <= wrData;
      pendReg      <= (pendReg & ~clrMask) | riseEdge;
      faultEvent   <= riseEdge & faultEnReg;
      funcResetReq <= |(riseEdge & rstEnReg & ~rstTypeReg);
      destHold     <= |(syncLvl & rstEnReg & rstTypeReg);
    end
  end

  always_comb begin
    case (regSel_e'(rdAddr))
      REG_RST_EN:   rdData = rstEnReg;
      REG_RST_TYPE: rdData = rstTypeReg;
      REG_PEND:     rdData = pendReg;
      REG_IRQ_EN:   rdData = irqEnReg;
      REG_FAULT_EN: rdData = faultEnReg;
      default:      rdData = '0;
    endcase
  end

  assign irq = |(pendReg & irqEnReg);

  // R2: every captured edge leaves its pending bit set
  a_r2_pend_captures: assert property (@(posedge clk) disable iff (!rstN)
    |riseEdge |=> ((pendReg & $past(riseEdge)) == $past(riseEdge)));

  // R9: a fault pulse is always accompanied by its pending bit
  a_r9_fault_has_pending: assert property (@(posedge clk) disable iff (!rstN)
    (faultEvent & ~pendReg) == '0);

  // R3: a locked detector never shows reset enable 0
  a_r3_lock_forces_one: assert property (@(posedge clk) disable iff (!rstN)
    (lockMask & ~rstEnReg) == '0);

  // R4: functional request only from a detector set up for it
  a_r4_func_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    funcResetReq |-> |($past(rstEnReg) & ~$past(rstTypeReg)));

  // R5: hold only from a detector set up for destructive reset
  a_r5_hold_needs_destructive: assert property (@(posedge clk) disable iff (!rstN)
    destHold |-> |($past(rstEnReg) & $past(rstTypeReg) & $past(syncLvl)));
endmodule

// File: rtl/vdr_reaction_ctrl.sv
module vdr_reaction_ctrl
  import vdr_pkg::*;
#(
  parameter int NUM_DET     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DET-1:0] detFlag,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_DET-1:0] busWrData,
  output logic [NUM_DET-1:0] busRdData,
  input  logic               bootLoad,
  input  logic [NUM_DET-1:0] bootEnable,
  output logic               irq,
  output logic [NUM_DET-1:0] faultEvent,
  output logic               funcResetReq,
  output logic               destHold,
  output logic               resetPinN
);
  logic [NUM_DET-1:0] syncLvl, riseEdge;
  ctrlStrobes_t       strobes;

  vdr_sync #(.NUM_DET(NUM_DET), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .rawFlag(detFlag),
    .syncLvl(syncLvl), .riseEdge(riseEdge)
  );

  vdr_ctrl uCtrl (
    .busWrEn(busWrEn), .busAddr(busAddr), .bootLoad(bootLoad), .strobes(strobes)
  );

  vdr_datapath #(.NUM_DET(NUM_DET)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .rdAddr(busAddr), .bootEnable(bootEnable), .syncLvl(syncLvl),
    .riseEdge(riseEdge), .rdData(busRdData), .irq(irq),
    .faultEvent(faultEvent), .funcResetReq(funcResetReq), .destHold(destHold)
  );

  assign resetPinN = ~destHold;
endmodule

// File: tb/vdr_reaction_ctrl_test.sv
module vdr_reaction_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] detFlag = '0;
  logic busWrEn = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [N-1:0] busWrData = '0;
  logic [N-1:0] busRdData;
  logic bootLoad = 1'b0;
  logic [N-1:0] bootEnable = '0;
  logic irq, funcResetReq, destHold, resetPinN;
  logic [N-1:0] faultEvent;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  vdr_reaction_ctrl #(.NUM_DET(N)) uut (
    .clk(clk), .rstN(rstN), .detFlag(detFlag), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .bootLoad(bootLoad), .bootEnable(bootEnable), .irq(irq),
    .faultEvent(faultEvent), .funcResetReq(funcResetReq),
    .destHold(destHold), .resetPinN(resetPinN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [N-1:0] hist[$];
  logic [N-1:0] mEn, mType, mPend, mIrqEn, mFaultEn, mLock, mFault;
  bit mFunc, mHold;

  task automatic modelReset();
    hist = {};
    for (int i = 0; i < 3; i++) hist.push_back('0);
    mEn = '0; mType = '1; mPend = '0; mIrqEn = '0; mFaultEn = '0; mLock = '0;
    mFault = '0; mFunc = 0; mHold = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      logic [N-1:0] lvl, prev, rise;
      lvl = hist[1]; prev = hist[0];
      rise = lvl & ~prev;
      mFault = rise & mFaultEn;
      mFunc = |(rise & mEn & ~mType);
      mHold = |(lvl & mEn & mType);
      if (busWrEn && busAddr == 3'd2) mPend = mPend & ~busWrData;
      mPend = mPend | rise;
      if (bootLoad) begin
        mLock = bootEnable;
        mEn = mEn | bootEnable;
      end else if (busWrEn && busAddr == 3'd0) mEn = busWrData | mLock;
      if (busWrEn && busAddr == 3'd1) mType = busWrData;
      if (busWrEn && busAddr == 3'd3) mIrqEn = busWrData;
      if (busWrEn && busAddr == 3'd4) mFaultEn = busWrData;
      hist.push_back(detFlag);
      void'(hist.pop_front());
    end
  end

  function automatic logic [N-1:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mEn;
      3'd1: return mType;
      3'd2: return mPend;
      3'd3: return mIrqEn;
      3'd4: return mFaultEn;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1/R3/R8", "busRdData", busRdData, expRead(busAddr));
      check("R7", "irq", N'(irq), N'(|(mPend & mIrqEn)));
      check("R9", "faultEvent", faultEvent, mFault);
      check("R4", "funcResetReq", N'(funcResetReq), N'(mFunc));
      check("R5/R6", "destHold", N'(destHold), N'(mHold));
      check("R5", "resetPinN", N'(resetPinN), N'(!mHold));
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic boot(input logic [N-1:0] en);
    bootLoad = 1'b1; bootEnable = en;
    step();
    bootLoad = 1'b0;
  endtask

  task automatic finish();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    step(3);
    // R1: reset state
    @(negedge clk);
    busAddr = 3'd1;
    #1 check("R1", "reset type default", busRdData, '1);
    check("R5", "reset pin idle", N'(resetPinN), N'(1));
    busAddr = 3'd0;
    step();
    rstN = 1'b1;
    step();
    for (int a = 0; a < 8; a++) begin
      busAddr = 3'(a);
      step();
    end

    // R9/R2: monitor only, pending set, nothing else
    detFlag[0] = 1'b1; busAddr = 3'd2;
    step(5);
    detFlag[0] = 1'b0;
    step(3);

    // R7: interrupt and write-one-to-clear
    wr(3'd3, 8'h01);
    busAddr = 3'd2;
    step(2);
    wr(3'd2, 8'h01);
    step(2);

    // R3: boot lock of detector 2, write of 0 ignored
    boot(8'h04);
    wr(3'd0, 8'h00);
    busAddr = 3'd0;
    step(2);

    // R5/R6: overlapping destructive conditions
    wr(3'd0, 8'h08);
    detFlag[2] = 1'b1;
    step(3);
    detFlag[3] = 1'b1;
    step(4);
    detFlag[2] = 1'b0;
    step(4);
    detFlag[3] = 1'b0;
    step(5);

    // R4: functional reset on detector 1, R9 fault on detector 4
    wr(3'd1, 8'hFD);
    wr(3'd0, 8'h02);
    wr(3'd4, 8'h10);
    detFlag[1] = 1'b1; detFlag[4] = 1'b1;
    step(6);
    detFlag = '0;
    step(3);

    // R7: capture wins over simultaneous clear on detector 5
    wr(3'd3, 8'h20);
    detFlag[5] = 1'b1;
    step(2);
    wr(3'd2, 8'h20);
    step(3);
    wr(3'd2, 8'h20);
    detFlag[5] = 1'b0;
    step(3);

    // R8: reboot with 0 unlocks detector 2
    boot(8'h00);
    busAddr = 3'd0;
    step(2);
    wr(3'd0, 8'h00);
    busAddr = 3'd0;
    step(2);

    // R3: boot and bus write in the same cycle
    busWrEn = 1'b1; busAddr = 3'd0; busWrData = 8'h00;
    bootLoad = 1'b1; bootEnable = 8'h81;
    step();
    busWrEn = 1'b0; bootLoad = 1'b0;
    step(2);

    // mixed random phase
    for (int i = 0; i < 1500; i++) begin
      detFlag = detFlag ^ N'($urandom_range(0, 255) & $urandom_range(0, 255) & $urandom_range(0, 255));
      busWrEn = ($urandom_range(0, 3) == 0);
      busAddr = 3'($urandom_range(0, 7));
      busWrData = N'($urandom_range(0, 255));
      bootLoad = ($urandom_range(0, 60) == 0);
      bootEnable = N'($urandom_range(0, 255));
      step();
    end
    busWrEn = 1'b0; bootLoad = 1'b0;
    step(4);
    finish();
  end
endmodule